// File: doc/BRIEF.md
# Line-Serial Tape Controller Register File

This block is the processor-facing register set of a tape controller that moves data one tape line at a time. The processor talks to it with a 3-bit I/O pulse code and a 12-bit accumulator bus. Three codes test flags and request a skip. Three codes move words in and out: a command word that selects the drive, the direction, run/stop and read/write, a data word, and a status word. One code reads the data register back. The block holds a 4-bit command register, a 12-bit data shift register, a 6-bit mark shift register, a per-line flag, a per-word flag with its modulo-4 line counter, and a timing-error flag.

The drive side is reduced to a line strobe. Each strobe carries the drive number, one mark-track bit and one 3-bit data nibble. When the strobe comes from the selected drive, the mark bit and the nibble shift into their registers. The top nibble of the data register is always presented for writing. Every fourth line closes a 12-bit word frame. If the processor has not serviced the previous frame when the next one closes, the block records a timing error and drops write mode. Drive motion, position and track synthesis lie outside the block. It only reports the selected drive, the direction and run/stop, and gives a one-cycle motion request when a command changes more than the read/write bit.

Top module: `tpc_regfile`

## Requirements
- R1: After reset the command, data, mark, both line flags, the line counter and the timing error are all zero. With no valid pulse, or with code 0, the accumulator passes through unchanged and skip is low.
- R2: Code 1 raises skip while the single-line flag is set. Code 2 raises skip while the timing error is set. Code 3 raises skip while the quad-line flag is set. These responses are combinational in the pulse cycle.
- R3: Code 4 loads the command register from accumulator bits 11:8 (bit 11 drive select, bit 10 reverse, bit 9 run, bit 8 write). It also clears the timing error and returns a zero accumulator.
- R4: Code 5 loads the data register from the accumulator. Codes 5, 6 and 7 each clear the single-line flag, the quad-line flag and the line counter.
- R5: Code 6 returns a status word. Bits 11:8 hold the command. Bit 7 is the write lock of the selected drive. Bit 6 is set on a timing error or when the selected drive is absent. Bits 5:0 hold the mark register.
- R6: Code 7 returns the data register.
- R7: Each accepted line sets the single-line flag and advances the line counter modulo 4. The line that wraps the counter sets the quad-line flag.
- R8: When a wrap finds the quad-line flag already set, the timing error sets and the command write bit clears in the same cycle.
- R9: Each accepted line shifts the mark register left by one and puts the new bit in bit 0, keeping 6 bits. It shifts the data register left by three and puts the new nibble in bits 2:0, keeping 12 bits.
- R10: The write nibble output is data register bits 11:9, taken before the shift. The write-active output follows the command write bit.
- R11: A code 4 that changes any command bit clears the mark register. A motion request pulses in the next cycle only when bits other than the write bit change.
- R12: A line strobe whose drive number differs from the selected drive changes no register.
- R13: When a pulse and a line strobe fall in the same cycle, the strobe acts on the result of the pulse. The drive selection used is the one held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_valid | input | 1 | I/O pulse present this cycle |
| pio_code | input | 3 | I/O pulse code |
| pio_acc_in | input | 12 | Accumulator from processor |
| pio_acc_out | output | 12 | Accumulator returned to processor |
| pio_skip | output | 1 | Skip request |
| line_stb | input | 1 | One tape line has passed a drive head |
| line_drive | input | 1 | Drive that produced the strobe |
| line_mark | input | 1 | Mark-track bit of the line |
| line_nib | input | 3 | Data nibble read from the line |
| drive_present | input | 2 | Per-drive present indication |
| drive_wlock | input | 2 | Per-drive write lock |
| wr_nib | output | 3 | Nibble to write on the next line |
| wr_active | output | 1 | Write mode selected |
| sel_drive | output | 1 | Selected drive |
| dir_rev | output | 1 | Reverse direction selected |
| run | output | 1 | Run selected |
| motion_req | output | 1 | One-cycle pulse after a motion-relevant command change |

## Verification
The timing error is the hardest state to reach. It needs two complete word frames from the selected drive with no clearing pulse in between, and a write command in force so that its forced drop is visible. The stimulus loads a write command and a data word, then sends eight consecutive selected strobes, and reads the skip, the status and the write-active output afterwards. A second hard case is a pulse and a strobe in the same cycle. It is driven both for a data load and for a command that switches drive selection, and the read-back data shows the ordering and which selection applied.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   typedef enum logic [2:0] {
      PIO_NOP       = 3'd0,
      PIO_SKIP_LINE = 3'd1,
      PIO_SKIP_TERR = 3'd2,
      PIO_SKIP_WORD = 3'd3,
      PIO_LOAD_CMD  = 3'd4,
      PIO_LOAD_DATA = 3'd5,
      PIO_READ_STAT = 3'd6,
      PIO_READ_DATA = 3'd7
   } pio_code_e;

   // Command field, held in the top four bits of the word; write is lowest.
   typedef struct packed {
      logic unit;
      logic rev;
      logic go;
      logic wr;
   } cmd_t;

   localparam int CMD_W = 4;

endpackage

// File: rtl/tpc_cmd_reg.sv
module tpc_cmd_reg
   import tpc_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] acc_in,
   input  logic              force_read,
   output cmd_t              cmd_q,
   output logic              changed,
   output logic              motion_req_q
);

   localparam int FIELD_LSB = WORD_W - CMD_W;

   generate
      if (WORD_W < 2 * CMD_W) begin : g_bad_width
         $error("tpc_cmd_reg: WORD_W too small for command field");
      end
   endgenerate

   cmd_t new_cmd;
   cmd_t diff;
   cmd_t cmd_nxt;
   logic motion;

   always_comb begin
      new_cmd = cmd_t'(acc_in[WORD_W-1:FIELD_LSB]);
      diff    = new_cmd ^ cmd_q;
      changed = load && (diff != '0);
      motion  = changed && (diff != cmd_t'(4'b0001));
      cmd_nxt = cmd_q;
      if (load) cmd_nxt = new_cmd;
      if (force_read) cmd_nxt.wr = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q        <= '0;
         motion_req_q <= 1'b0;
      end else begin
         cmd_q        <= cmd_nxt;
         motion_req_q <= motion;
      end
   end

   a_r11_rw_only_no_motion: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ((new_cmd ^ cmd_q) == cmd_t'(4'b0001))) |=> !motion_req_q);

endmodule

// File: rtl/tpc_line_framer.sv
module tpc_line_framer #(
   parameter int LINES_PER_WORD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_flags,
   input  logic clr_terr,
   input  logic accept,
   output logic slf_q,
   output logic qlf_q,
   output logic terr_q,
   output logic terr_event
);

   localparam int CW = (LINES_PER_WORD > 1) ? $clog2(LINES_PER_WORD) : 1;
   localparam logic [CW-1:0] LAST = CW'(LINES_PER_WORD - 1);

   generate
      if (LINES_PER_WORD < 2) begin : g_bad_lpw
         $error("tpc_line_framer: LINES_PER_WORD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] ctr_q, ctr_base, ctr_nxt;
   logic slf_base, qlf_base, terr_base;
   logic slf_nxt, qlf_nxt, terr_nxt;
   logic wrap;

   always_comb begin
      slf_base  = clr_flags ? 1'b0 : slf_q;
      qlf_base  = clr_flags ? 1'b0 : qlf_q;
      ctr_base  = clr_flags ? '0   : ctr_q;
      terr_base = clr_terr  ? 1'b0 : terr_q;
      wrap       = accept && (ctr_base == LAST);
      terr_event = wrap && qlf_base;
      slf_nxt  = slf_base | accept;
      ctr_nxt  = ctr_base;
      if (accept) ctr_nxt = wrap ? '0 : ctr_base + 1'b1;
      qlf_nxt  = qlf_base | (wrap && !qlf_base);
      terr_nxt = terr_base | terr_event;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slf_q  <= 1'b0;
         qlf_q  <= 1'b0;
         terr_q <= 1'b0;
         ctr_q  <= '0;
      end else begin
         slf_q  <= slf_nxt;
         qlf_q  <= qlf_nxt;
         terr_q <= terr_nxt;
         ctr_q  <= ctr_nxt;
      end
   end

   a_r7_line_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> slf_q);

   a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flags && !accept) |=> (!slf_q && !qlf_q));

endmodule

// File: rtl/tpc_shift_regs.sv
module tpc_shift_regs #(
   parameter int WORD_W = 12,
   parameter int NIB_W  = 3,
   parameter int MARK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_data,
   input  logic [WORD_W-1:0] acc_in,
   input  logic              clr_mark,
   input  logic              accept,
   input  logic              mark_bit,
   input  logic [NIB_W-1:0]  nib_in,
   output logic [WORD_W-1:0] data_q,
   output logic [MARK_W-1:0] mark_q,
   output logic [NIB_W-1:0]  wr_nib
);

   generate
      if (WORD_W % NIB_W != 0) begin : g_bad_nib
         $error("tpc_shift_regs: WORD_W must be a multiple of NIB_W");
      end
      if (MARK_W < 2) begin : g_bad_mark
         $error("tpc_shift_regs: MARK_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] data_base, data_nxt;
   logic [MARK_W-1:0] mark_base, mark_nxt;

   always_comb begin
      data_base = load_data ? acc_in : data_q;
      mark_base = clr_mark ? '0 : mark_q;
      data_nxt  = data_base;
      mark_nxt  = mark_base;
      if (accept) begin
         data_nxt = {data_base[WORD_W-NIB_W-1:0], nib_in};
         mark_nxt = {mark_base[MARK_W-2:0], mark_bit};
      end
   end

   assign wr_nib = data_q[WORD_W-1 -: NIB_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         mark_q <= '0;
      end else begin
         data_q <= data_nxt;
         mark_q <= mark_nxt;
      end
   end

   a_r9_mark_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !clr_mark) |=>
         (mark_q == {$past(mark_q[MARK_W-2:0]), $past(mark_bit)}));

endmodule

// File: rtl/tpc_pio_mux.sv
module tpc_pio_mux
   import tpc_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int MARK_W = 6
) (
   input  logic              valid,
   input  logic [2:0]        code,
   input  logic [WORD_W-1:0] acc_in,
   input  cmd_t              cmd,
   input  logic [MARK_W-1:0] mark,
   input  logic [WORD_W-1:0] data,
   input  logic              slf,
   input  logic              qlf,
   input  logic              terr,
   input  logic              absent,
   input  logic              wlock,
   output logic [WORD_W-1:0] acc_out,
   output logic              skip
);

   localparam int ERR_BIT  = MARK_W;
   localparam int LOCK_BIT = MARK_W + 1;

   generate
      if (LOCK_BIT >= WORD_W - CMD_W) begin : g_bad_status
         $error("tpc_pio_mux: status fields overlap the command field");
      end
   endgenerate

   logic [WORD_W-1:0] status;

   always_comb begin
      status = '0;
      status[WORD_W-1 -: CMD_W] = cmd;
      status[MARK_W-1:0]        = mark;
      status[ERR_BIT]           = terr | absent;
      status[LOCK_BIT]          = wlock;
   end

   always_comb begin
      acc_out = acc_in;
      skip    = 1'b0;
      if (valid) begin
         case (pio_code_e'(code))
            PIO_SKIP_LINE: skip = slf;
            PIO_SKIP_TERR: skip = terr;
            PIO_SKIP_WORD: skip = qlf;
            PIO_LOAD_CMD:  acc_out = '0;
            PIO_READ_STAT: acc_out = status;
            PIO_READ_DATA: acc_out = data;
            default:       acc_out = acc_in;
         endcase
      end
   end

endmodule

// File: rtl/tpc_regfile.sv
module tpc_regfile
   import tpc_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int NIB_W      = 3,
   parameter int MARK_W     = 6,
   parameter int NUM_DRIVES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pio_valid,
   input  logic [2:0]            pio_code,
   input  logic [WORD_W-1:0]     pio_acc_in,
   output logic [WORD_W-1:0]     pio_acc_out,
   output logic                  pio_skip,
   input  logic                  line_stb,
   input  logic                  line_drive,
   input  logic                  line_mark,
   input  logic [NIB_W-1:0]      line_nib,
   input  logic [NUM_DRIVES-1:0] drive_present,
   input  logic [NUM_DRIVES-1:0] drive_wlock,
   output logic [NIB_W-1:0]      wr_nib,
   output logic                  wr_active,
   output logic                  sel_drive,
   output logic                  dir_rev,
   output logic                  run,
   output logic                  motion_req
);

   localparam int LINES_PER_WORD = WORD_W / NIB_W;

   generate
      if (NUM_DRIVES != 2) begin : g_bad_drives
         $error("tpc_regfile: one select bit addresses exactly two drives");
      end
   endgenerate

   cmd_t cmd_q;
   logic cmd_changed;
   logic is_load_cmd, is_load_data, is_clear;
   logic accept;
   logic slf_q, qlf_q, terr_q, terr_event;
   logic [WORD_W-1:0] data_q;
   logic [MARK_W-1:0] mark_q;

   always_comb begin
      is_load_cmd  = pio_valid && (pio_code == PIO_LOAD_CMD);
      is_load_data = pio_valid && (pio_code == PIO_LOAD_DATA);
      is_clear     = pio_valid && ((pio_code == PIO_LOAD_DATA) ||
                                   (pio_code == PIO_READ_STAT) ||
                                   (pio_code == PIO_READ_DATA));
      accept       = line_stb && (line_drive == cmd_q.unit);
   end

   tpc_cmd_reg #(.WORD_W(WORD_W)) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (is_load_cmd),
      .acc_in       (pio_acc_in),
      .force_read   (terr_event),
      .cmd_q        (cmd_q),
      .changed      (cmd_changed),
      .motion_req_q (motion_req)
   );

   tpc_line_framer #(.LINES_PER_WORD(LINES_PER_WORD)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_flags  (is_clear),
      .clr_terr   (is_load_cmd),
      .accept     (accept),
      .slf_q      (slf_q),
      .qlf_q      (qlf_q),
      .terr_q     (terr_q),
      .terr_event (terr_event)
   );

   tpc_shift_regs #(.WORD_W(WORD_W), .NIB_W(NIB_W), .MARK_W(MARK_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_data (is_load_data),
      .acc_in    (pio_acc_in),
      .clr_mark  (cmd_changed),
      .accept    (accept),
      .mark_bit  (line_mark),
      .nib_in    (line_nib),
      .data_q    (data_q),
      .mark_q    (mark_q),
      .wr_nib    (wr_nib)
   );

   tpc_pio_mux #(.WORD_W(WORD_W), .MARK_W(MARK_W)) u_mux (
      .valid   (pio_valid),
      .code    (pio_code),
      .acc_in  (pio_acc_in),
      .cmd     (cmd_q),
      .mark    (mark_q),
      .data    (data_q),
      .slf     (slf_q),
      .qlf     (qlf_q),
      .terr    (terr_q),
      .absent  (!drive_present[cmd_q.unit]),
      .wlock   (drive_wlock[cmd_q.unit]),
      .acc_out (pio_acc_out),
      .skip    (pio_skip)
   );

   assign wr_active = cmd_q.wr;
   assign sel_drive = cmd_q.unit;
   assign dir_rev   = cmd_q.rev;
   assign run       = cmd_q.go;

   a_r8_terr_forces_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(terr_q) |-> !wr_active);

   a_r12_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb && (line_drive != sel_drive) && !pio_valid) |=>
         ($stable(data_q) && $stable(mark_q) && $stable(slf_q)));

endmodule

// File: tb/tpc_regfile_test.sv
module tpc_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pio_valid = 1'b0;
   logic [2:0]  pio_code = 3'd0;
   logic [11:0] pio_acc_in = '0;
   logic [11:0] pio_acc_out;
   logic        pio_skip;
   logic        line_stb = 1'b0;
   logic        line_drive = 1'b0;
   logic        line_mark = 1'b0;
   logic [2:0]  line_nib = '0;
   logic [1:0]  drive_present = 2'b11;
   logic [1:0]  drive_wlock = 2'b00;
   logic [2:0]  wr_nib;
   logic        wr_active, sel_drive, dir_rev, run, motion_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tpc_regfile uut (
      .clk(clk), .rst_n(rst_n),
      .pio_valid(pio_valid), .pio_code(pio_code),
      .pio_acc_in(pio_acc_in), .pio_acc_out(pio_acc_out), .pio_skip(pio_skip),
      .line_stb(line_stb), .line_drive(line_drive), .line_mark(line_mark),
      .line_nib(line_nib), .drive_present(drive_present), .drive_wlock(drive_wlock),
      .wr_nib(wr_nib), .wr_active(wr_active), .sel_drive(sel_drive),
      .dir_rev(dir_rev), .run(run), .motion_req(motion_req)
   );

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %o expected %o", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [2:0] c, input logic [11:0] a,
                        output logic [11:0] r, output logic s);
      @(negedge clk);
      pio_valid = 1'b1; pio_code = c; pio_acc_in = a;
      #1;
      r = pio_acc_out; s = pio_skip;
      @(posedge clk); #1;
      pio_valid = 1'b0; pio_code = 3'd0;
   endtask

   task automatic line(input logic d, input logic m, input logic [2:0] n);
      @(negedge clk);
      line_stb = 1'b1; line_drive = d; line_mark = m; line_nib = n;
      @(posedge clk); #1;
      line_stb = 1'b0;
   endtask

   task automatic both(input logic [2:0] c, input logic [11:0] a,
                       input logic d, input logic m, input logic [2:0] n);
      @(negedge clk);
      pio_valid = 1'b1; pio_code = c; pio_acc_in = a;
      line_stb = 1'b1; line_drive = d; line_mark = m; line_nib = n;
      @(posedge clk); #1;
      pio_valid = 1'b0; pio_code = 3'd0; line_stb = 1'b0;
   endtask

   task automatic t_reset;
      logic [11:0] r; logic s;
      @(negedge clk); pio_acc_in = 12'o4321; #1;
      chk("R1 passthrough", pio_acc_out, 12'o4321);
      chk("R1 skip idle", {11'd0, pio_skip}, 12'd0);
      pulse(3'd1, 12'o0, r, s); chk("R1 R2 line flag clear", {11'd0, s}, 12'd0);
      pulse(3'd2, 12'o0, r, s); chk("R2 no timing error", {11'd0, s}, 12'd0);
      pulse(3'd6, 12'o0, r, s); chk("R1 R5 status zero", r, 12'o0000);
      pulse(3'd7, 12'o0, r, s); chk("R1 R6 data zero", r, 12'o0000);
      drive_present = 2'b10;
      pulse(3'd6, 12'o0, r, s); chk("R5 absent drive", r, 12'o0100);
      drive_present = 2'b11;
   endtask

   task automatic t_cmd;
      logic [11:0] r; logic s;
      drive_wlock = 2'b10;
      pulse(3'd4, 12'o7777, r, s); chk("R3 zero acc", r, 12'o0000);
      chk("R3 select out", {9'd0, sel_drive, dir_rev, run}, 12'o7);
      pulse(3'd6, 12'o0, r, s); chk("R3 R5 masked cmd and lock", r, 12'o7600);
      drive_present = 2'b01;
      pulse(3'd6, 12'o0, r, s); chk("R5 absent selected", r, 12'o7700);
      drive_present = 2'b11; drive_wlock = 2'b00;
   endtask

   task automatic t_framing;
      logic [11:0] r; logic s;
      pulse(3'd4, 12'o1000, r, s);
      chk("R11 motion on start", {11'd0, motion_req}, 12'd1);
      pulse(3'd7, 12'o0, r, s);
      line(1'b0, 1'b1, 3'd1);
      pulse(3'd1, 12'o0, r, s); chk("R7 line flag", {11'd0, s}, 12'd1);
      pulse(3'd3, 12'o0, r, s); chk("R7 no word yet", {11'd0, s}, 12'd0);
      line(1'b0, 1'b0, 3'd2);
      line(1'b0, 1'b1, 3'd3);
      pulse(3'd3, 12'o0, r, s); chk("R7 three lines", {11'd0, s}, 12'd0);
      line(1'b0, 1'b1, 3'd4);
      pulse(3'd3, 12'o0, r, s); chk("R7 word flag at fourth", {11'd0, s}, 12'd1);
      pulse(3'd6, 12'o0, r, s); chk("R9 R5 mark in status", r, 12'o1013);
      pulse(3'd7, 12'o0, r, s); chk("R9 R6 data assembled", r, 12'o1234);
      pulse(3'd1, 12'o0, r, s); chk("R4 flag cleared by read", {11'd0, s}, 12'd0);
      line(1'b0, 1'b1, 3'd5);
      line(1'b0, 1'b1, 3'd6);
      line(1'b0, 1'b1, 3'd7);
      pulse(3'd6, 12'o0, r, s); chk("R9 mark truncation", r, 12'o1037);
      pulse(3'd7, 12'o0, r, s); chk("R9 data truncation", r, 12'o4567);
   endtask

   task automatic t_timing;
      logic [11:0] r; logic s;
      pulse(3'd4, 12'o1400, r, s);
      pulse(3'd5, 12'o5432, r, s);
      chk("R10 write nibble", {9'd0, wr_nib}, 12'd5);
      chk("R10 write active", {11'd0, wr_active}, 12'd1);
      line(1'b0, 1'b0, 3'd0);
      chk("R10 nibble after shift", {9'd0, wr_nib}, 12'd4);
      for (int i = 0; i < 7; i++) line(1'b0, 1'b0, 3'd0);
      pulse(3'd2, 12'o0, r, s); chk("R8 timing error skip", {11'd0, s}, 12'd1);
      chk("R8 write dropped", {11'd0, wr_active}, 12'd0);
      pulse(3'd6, 12'o0, r, s); chk("R8 R5 status error", r, 12'o1100);
      pulse(3'd4, 12'o1000, r, s);
      pulse(3'd2, 12'o0, r, s); chk("R3 timing error cleared", {11'd0, s}, 12'd0);
   endtask

   task automatic t_unselected;
      logic [11:0] r; logic s;
      pulse(3'd4, 12'o0000, r, s);
      pulse(3'd4, 12'o1000, r, s);
      pulse(3'd5, 12'o0123, r, s);
      line(1'b1, 1'b1, 3'd7);
      pulse(3'd1, 12'o0, r, s); chk("R12 flag untouched", {11'd0, s}, 12'd0);
      pulse(3'd6, 12'o0, r, s); chk("R12 mark untouched", r, 12'o1000);
      pulse(3'd7, 12'o0, r, s); chk("R12 data untouched", r, 12'o0123);
   endtask

   task automatic t_markclr;
      logic [11:0] r; logic s;
      line(1'b0, 1'b1, 3'd0);
      pulse(3'd6, 12'o0, r, s); chk("R9 mark one", r, 12'o1001);
      pulse(3'd4, 12'o1400, r, s);
      chk("R11 write-only no motion", {11'd0, motion_req}, 12'd0);
      pulse(3'd6, 12'o0, r, s); chk("R11 mark cleared", r, 12'o1400);
      pulse(3'd4, 12'o3400, r, s);
      chk("R11 direction motion", {11'd0, motion_req}, 12'd1);
   endtask

   task automatic t_simul;
      logic [11:0] r; logic s;
      pulse(3'd4, 12'o1000, r, s);
      pulse(3'd7, 12'o0, r, s);
      both(3'd5, 12'o0007, 1'b0, 1'b1, 3'd3);
      pulse(3'd1, 12'o0, r, s); chk("R13 flag after load", {11'd0, s}, 12'd1);
      pulse(3'd7, 12'o0, r, s); chk("R13 load then shift", r, 12'o0073);
      both(3'd4, 12'o5000, 1'b0, 1'b1, 3'd2);
      chk("R13 new select", {11'd0, sel_drive}, 12'd1);
      pulse(3'd7, 12'o0, r, s); chk("R13 old select used", r, 12'o0732);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_cmd();
      t_framing();
      t_timing();
      t_unselected();
      t_markclr();
      t_simul();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule